// File: doc/BRIEF.md
# Latched Alarm Status Unit

This unit sits beside a line framer and turns its raw condition signals into host-visible status. Single-cycle event pulses and steady alarm levels are captured in sticky bits inside three latched registers: two status registers that can raise an interrupt, and one information register that never does. The host never sees the sticky bits directly. It sees a per-bit read copy, and it controls that copy with a two-write protocol. The first write of a mask refreshes the selected bits of the copy. The host then reads the register. A second write, carrying the read value ANDed with the mask, clears the sticky bits it has now seen. The host can therefore poll single bits without disturbing the rest of the register, and an event that arrives between the accesses is never lost.

Alarm bits follow the alarm level. A sticky alarm bit cannot be cleared while the alarm is still present. Its interrupt request is raised by any change of the level, rising or falling. Event bits raise their interrupt request when they latch. Two enable registers select which status bits reach the active-low interrupt output. A live synchronizer status byte can be read at any time with no prior write.

Top module: `alst_unit`

## Requirements
- R1: After reset all read copies, sticky bits and interrupt enables are zero, `rdata_o` is 0 and `int_n_o` is high.
- R2: A one-cycle pulse on an event input sets its sticky bit, and the bit stays set until a clearing write removes it.
- R3: A write to a latched register (address 0 = status A, 1 = status B, 2 = information) refreshes each bit written as 1 that has not been refreshed since it was last cleared. The refresh loads the bit's sticky value into the read copy. Bits written as 0 keep their read copy.
- R4: A write with a 1 on a bit that has already been refreshed clears that sticky bit and leaves the read copy unchanged. The next refresh of the bit then shows 0.
- R5: If an input sets a bit in the same cycle as a clearing write to that bit, the bit stays set.
- R6: Alarm bits (status A bits 3:0, information bits 1:0) are set while their input is high. A clearing write leaves the bit at 1 while the alarm persists, and clears it once the alarm has gone.
- R7: Address 3 returns the live synchronizer input with no prior write, and writes to address 3 change nothing.
- R8: Address 4 holds the interrupt enables for status A and address 5 holds those for status B. Both are readable, and a 1 enables the bit.
- R9: An enabled event bit (status A bits 7:4, all of status B) that is set drives `int_n_o` low from the clock edge that latches it. `int_n_o` returns high after the clearing write if nothing else is pending.
- R10: An enabled alarm bit drives `int_n_o` low after each change of its alarm, rising or falling. The clearing write releases the request even while the alarm persists.
- R11: Bits of the information register never affect `int_n_o`.
- R12: `rdata_o` loads the addressed register at the clock edge on which `rd_en_i` is high and holds otherwise. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data / mask |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 8 | Registered read data |
| sa_src_i | input | 8 | Status A sources: bits 3:0 alarm levels, bits 7:4 event pulses |
| sb_src_i | input | 8 | Status B event pulses |
| inf_src_i | input | 8 | Information sources: bits 1:0 alarm levels, bits 7:2 event pulses |
| sync_i | input | 8 | Live synchronizer status |
| int_n_o | output | 1 | Active-low interrupt |

## Verification
Sticky bits and change requests load at the clock edge where the source is present. The interrupt output is decoded without a register from that state, so it is due just after the same edge. Write effects are due at the edge on which the strobe is high. Read data is due one edge after `rd_en_i`. The bench drives every input on the falling edge and holds each strobe for exactly one rising edge. It samples outputs on a later falling edge, half a cycle after the edge that made them due, so no check races the edge it depends on.

// File: rtl/alst_pkg.sv
package alst_pkg;

    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 3;
    localparam int NUM_LATCHED = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_STAT_A = 3'd0,
        A_STAT_B = 3'd1,
        A_INFO   = 3'd2,
        A_SYNC   = 3'd3,
        A_IEN_A  = 3'd4,
        A_IEN_B  = 3'd5
    } reg_addr_e;

    // State of one latched register, one bit per source.
    typedef struct packed {
        logic [DATA_W-1:0] sticky;  // captured condition
        logic [DATA_W-1:0] armed;   // refreshed, awaiting clearing write
        logic [DATA_W-1:0] held;    // host-visible copy
        logic [DATA_W-1:0] chg;     // pending alarm change request
    } lreg_t;

    function automatic logic [DATA_W-1:0] merge_sel(
        input logic [DATA_W-1:0] oldv,
        input logic [DATA_W-1:0] sel,
        input logic [DATA_W-1:0] newv
    );
        return (oldv & ~sel) | (newv & sel);
    endfunction

endpackage

// File: rtl/alst_edge_det.sv
module alst_edge_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] chg_o
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl_i;
    end

    assign chg_o = lvl_i ^ prev_q;

endmodule

// File: rtl/alst_latch_reg.sv
module alst_latch_reg
    import alst_pkg::*;
#(
    parameter logic [DATA_W-1:0] LEVEL_MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] src_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] held_o,
    output logic [DATA_W-1:0] pend_o
);

    lreg_t             st_q, st_d;
    logic [DATA_W-1:0] edge_w;
    logic [DATA_W-1:0] refresh;
    logic [DATA_W-1:0] clr;
    logic [DATA_W-1:0] avail;

    alst_edge_det #(.W(DATA_W)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (src_i & LEVEL_MASK),
        .chg_o (edge_w)
    );

    always_comb begin
        refresh      = wr_i ? (wdata_i & ~st_q.armed) : '0;
        clr          = wr_i ? (wdata_i &  st_q.armed) : '0;
        avail        = st_q.sticky | src_i;
        // a set in the clearing cycle wins over the clear
        st_d.sticky  = (st_q.sticky & ~clr) | src_i;
        st_d.held    = merge_sel(st_q.held, refresh, avail);
        st_d.armed   = merge_sel(st_q.armed & ~clr, refresh, avail);
        st_d.chg     = (st_q.chg & ~clr) | edge_w;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign held_o = st_q.held;
    assign pend_o = (st_q.sticky & ~LEVEL_MASK) | (st_q.chg & LEVEL_MASK);

    // R2 / R5: any present source is latched at the next edge
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|src_i) |=> ((st_q.sticky & $past(src_i)) == $past(src_i)));

    // R3: bits written as zero keep their read copy
    a_r3_zero_bits_hold: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (((st_q.held ^ $past(st_q.held)) & ~$past(wdata_i)) == '0));

    // R3: without a write the read copy never moves
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(st_q.held));

    // R4: an armed bit written as one, with no source present, clears
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_i && (|(wdata_i & st_q.armed & ~src_i)))
        |=> ((st_q.sticky & $past(wdata_i & st_q.armed & ~src_i)) == '0));

    // R10: every alarm change leaves a pending request
    a_r10_change_pending: assert property (@(posedge clk) disable iff (rst)
        (|edge_w) |=> ((st_q.chg & $past(edge_w)) == $past(edge_w)));

endmodule

// File: rtl/alst_irq_gen.sv
module alst_irq_gen #(
    parameter int NR = 3,
    parameter int W  = 8
) (
    input  logic [NR-1:0][W-1:0] pend_i,
    input  logic [NR-1:0][W-1:0] en_i,
    output logic                 int_n_o
);

    logic [NR-1:0] hit;

    for (genvar g = 0; g < NR; g++) begin : g_hit
        assign hit[g] = |(pend_i[g] & en_i[g]);
    end

    assign int_n_o = ~|hit;

endmodule

// File: rtl/alst_unit.sv
module alst_unit
    import alst_pkg::*;
#(
    parameter logic [DATA_W-1:0] LEVEL_A = 8'h0F,
    parameter logic [DATA_W-1:0] LEVEL_B = 8'h00,
    parameter logic [DATA_W-1:0] LEVEL_I = 8'h03
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [DATA_W-1:0] sa_src_i,
    input  logic [DATA_W-1:0] sb_src_i,
    input  logic [DATA_W-1:0] inf_src_i,
    input  logic [DATA_W-1:0] sync_i,
    output logic              int_n_o
);

    localparam logic [NUM_LATCHED-1:0][DATA_W-1:0] LVL_ARR = {LEVEL_I, LEVEL_B, LEVEL_A};

    logic [NUM_LATCHED-1:0][DATA_W-1:0] src_arr;
    logic [NUM_LATCHED-1:0][DATA_W-1:0] held_arr;
    logic [NUM_LATCHED-1:0][DATA_W-1:0] pend_arr;
    logic [NUM_LATCHED-1:0][DATA_W-1:0] en_arr;
    logic [NUM_LATCHED-1:0]             wr_sel;
    logic [DATA_W-1:0]                  ien_a_q, ien_b_q, rdata_q;

    assign src_arr = {inf_src_i, sb_src_i, sa_src_i};
    // information register has no enable: it never interrupts
    assign en_arr  = {{DATA_W{1'b0}}, ien_b_q, ien_a_q};

    for (genvar g = 0; g < NUM_LATCHED; g++) begin : g_lreg
        assign wr_sel[g] = wr_en_i && (addr_i == ADDR_W'(g));
        alst_latch_reg #(.LEVEL_MASK(LVL_ARR[g])) u_lreg (
            .clk     (clk),
            .rst     (rst),
            .src_i   (src_arr[g]),
            .wr_i    (wr_sel[g]),
            .wdata_i (wdata_i),
            .held_o  (held_arr[g]),
            .pend_o  (pend_arr[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_a_q <= '0;
            ien_b_q <= '0;
        end else if (wr_en_i) begin
            if (addr_i == A_IEN_A) ien_a_q <= wdata_i;
            if (addr_i == A_IEN_B) ien_b_q <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_en_i) begin
            case (reg_addr_e'(addr_i))
                A_STAT_A: rdata_q <= held_arr[0];
                A_STAT_B: rdata_q <= held_arr[1];
                A_INFO:   rdata_q <= held_arr[2];
                A_SYNC:   rdata_q <= sync_i;
                A_IEN_A:  rdata_q <= ien_a_q;
                A_IEN_B:  rdata_q <= ien_b_q;
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign rdata_o = rdata_q;

    alst_irq_gen #(.NR(NUM_LATCHED), .W(DATA_W)) u_irq (
        .pend_i  (pend_arr),
        .en_i    (en_arr),
        .int_n_o (int_n_o)
    );

    // R9 / R10: the interrupt is only released by a host write
    a_r9_release_after_write: assert property (@(posedge clk) disable iff (rst)
        $rose(int_n_o) |-> $past(wr_en_i));

    // R7: synchronizer read returns the live input of the read cycle
    a_r7_sync_live: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && addr_i == A_SYNC) |=> (rdata_o == $past(sync_i)));

    // R12: read data holds while no read is strobed
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> $stable(rdata_o));

endmodule

// File: tb/alst_unit_tb.sv
module alst_unit_tb;

    localparam logic [3:0] OP_WR  = 4'd0;
    localparam logic [3:0] OP_RD  = 4'd1;
    localparam logic [3:0] OP_EVA = 4'd2;
    localparam logic [3:0] OP_EVB = 4'd3;
    localparam logic [3:0] OP_EVI = 4'd4;
    localparam logic [3:0] OP_LVA = 4'd5;
    localparam logic [3:0] OP_INT = 4'd6;

    typedef struct packed {
        logic [3:0] op;
        logic [2:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 44;
    localparam vec_t VEC [NV] = '{
        '{OP_EVA, 3'd0, 8'h10, 8'h00, 8'd2},
        '{OP_RD,  3'd0, 8'h00, 8'h00, 8'd3},   // R3 not yet refreshed
        '{OP_WR,  3'd0, 8'h10, 8'h00, 8'd3},
        '{OP_RD,  3'd0, 8'h00, 8'h10, 8'd3},   // R3 refreshed
        '{OP_WR,  3'd0, 8'h10, 8'h00, 8'd4},
        '{OP_RD,  3'd0, 8'h00, 8'h10, 8'd4},   // R4 copy kept
        '{OP_WR,  3'd0, 8'h10, 8'h00, 8'd4},
        '{OP_RD,  3'd0, 8'h00, 8'h00, 8'd4},   // R4 cleared
        '{OP_EVB, 3'd1, 8'h81, 8'h00, 8'd2},
        '{OP_WR,  3'd1, 8'h01, 8'h00, 8'd3},
        '{OP_RD,  3'd1, 8'h00, 8'h01, 8'd3},   // R3 bit7 not selected
        '{OP_WR,  3'd1, 8'h80, 8'h00, 8'd3},
        '{OP_RD,  3'd1, 8'h00, 8'h81, 8'd2},   // R2 bit7 still latched
        '{OP_WR,  3'd5, 8'h02, 8'h00, 8'd8},
        '{OP_INT, 3'd0, 8'h00, 8'h01, 8'd8},   // R8 masked bits silent
        '{OP_EVB, 3'd1, 8'h02, 8'h00, 8'd9},
        '{OP_INT, 3'd0, 8'h00, 8'h00, 8'd9},   // R9 low
        '{OP_WR,  3'd1, 8'h02, 8'h00, 8'd9},
        '{OP_INT, 3'd0, 8'h00, 8'h00, 8'd9},   // R9 refresh alone keeps low
        '{OP_WR,  3'd1, 8'h02, 8'h00, 8'd9},
        '{OP_INT, 3'd0, 8'h00, 8'h01, 8'd9},   // R9 released
        '{OP_WR,  3'd4, 8'h01, 8'h00, 8'd10},
        '{OP_LVA, 3'd0, 8'h01, 8'h00, 8'd10},
        '{OP_INT, 3'd0, 8'h00, 8'h00, 8'd10},  // R10 rising change
        '{OP_WR,  3'd0, 8'h01, 8'h00, 8'd10},
        '{OP_WR,  3'd0, 8'h01, 8'h00, 8'd10},
        '{OP_INT, 3'd0, 8'h00, 8'h01, 8'd10},  // R10 released while present
        '{OP_WR,  3'd0, 8'h01, 8'h00, 8'd6},
        '{OP_RD,  3'd0, 8'h00, 8'h01, 8'd6},   // R6 still set
        '{OP_LVA, 3'd0, 8'h00, 8'h00, 8'd10},
        '{OP_INT, 3'd0, 8'h00, 8'h00, 8'd10},  // R10 falling change
        '{OP_WR,  3'd0, 8'h01, 8'h00, 8'd6},
        '{OP_INT, 3'd0, 8'h00, 8'h01, 8'd10},
        '{OP_WR,  3'd0, 8'h01, 8'h00, 8'd6},
        '{OP_RD,  3'd0, 8'h00, 8'h00, 8'd6},   // R6 cleared after alarm gone
        '{OP_RD,  3'd3, 8'h00, 8'h5A, 8'd7},   // R7 live
        '{OP_WR,  3'd3, 8'hFF, 8'h00, 8'd7},
        '{OP_RD,  3'd3, 8'h00, 8'h5A, 8'd7},   // R7 write ignored
        '{OP_RD,  3'd4, 8'h00, 8'h01, 8'd8},
        '{OP_RD,  3'd5, 8'h00, 8'h02, 8'd8},
        '{OP_RD,  3'd6, 8'h00, 8'h00, 8'd12},  // R12 unmapped
        '{OP_EVI, 3'd2, 8'h80, 8'h00, 8'd11},
        '{OP_INT, 3'd0, 8'h00, 8'h01, 8'd11},  // R11 info silent
        '{OP_RD,  3'd2, 8'h00, 8'h00, 8'd11}   // info not refreshed yet
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic [3:0] ev_a = '0;
    logic [3:0] lvl_a = '0;
    logic [7:0] sb = '0;
    logic [7:0] inf = '0;
    logic [7:0] sync_v = 8'h5A;
    logic       int_n;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    alst_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .rdata_o   (rdata),
        .sa_src_i  ({ev_a, lvl_a}),
        .sb_src_i  (sb),
        .inf_src_i (inf),
        .sync_i    (sync_v),
        .int_n_o   (int_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input int which, input logic [7:0] d);
        @(negedge clk);
        case (which)
            0: ev_a = d[7:4];
            1: sb = d;
            default: inf = d;
        endcase
        @(negedge clk);
        ev_a = '0; sb = '0; inf = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 int_n", {7'd0, int_n}, 8'h01);
        chk("R1 rdata", rdata, 8'h00);
        rd(3'd4, d); chk("R1 ien_a", d, 8'h00);
        rd(3'd1, d); chk("R1 stat_b", d, 8'h00);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            case (VEC[i].op)
                OP_WR:  wr(VEC[i].addr, VEC[i].data);
                OP_RD:  begin rd(VEC[i].addr, d); chk(tag, d, VEC[i].exp); end
                OP_EVA: pulse(0, VEC[i].data);
                OP_EVB: pulse(1, VEC[i].data);
                OP_EVI: pulse(2, VEC[i].data);
                OP_LVA: begin @(negedge clk); lvl_a = VEC[i].data[3:0]; @(negedge clk); end
                default: begin @(negedge clk); chk(tag, {7'd0, int_n}, VEC[i].exp); end
            endcase
        end

        // R2 information event latched, readable after refresh
        wr(3'd2, 8'h80);
        rd(3'd2, d); chk("R2 info latched", d, 8'h80);

        // R5 set in the same cycle as the clearing write survives
        pulse(1, 8'h08);
        wr(3'd1, 8'h08);
        @(negedge clk);
        addr = 3'd1; wdata = 8'h08; wr_en = 1'b1; sb = 8'h08;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; sb = '0;
        wr(3'd1, 8'h08);
        rd(3'd1, d); chk("R5 set wins", d & 8'h08, 8'h08);
        wr(3'd1, 8'h08);
        wr(3'd1, 8'h08);
        rd(3'd1, d); chk("R4 later clear", d & 8'h08, 8'h00);

        // R9 enabled event bit of status A
        wr(3'd4, 8'hFF);
        pulse(0, 8'h20);
        chk("R9 stat_a event low", {7'd0, int_n}, 8'h00);
        wr(3'd0, 8'h20);
        wr(3'd0, 8'h20);
        chk("R9 stat_a event released", {7'd0, int_n}, 8'h01);

        // R12 read data holds without a strobe
        rd(3'd3, d);
        sync_v = 8'hA5;
        repeat (3) @(negedge clk);
        chk("R12 hold", rdata, 8'h5A);
        rd(3'd3, d); chk("R7 live update", d, 8'hA5);
        rd(3'd7, d); chk("R12 addr7", d, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule